// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit decodes and executes one vector-length configuration instruction. It reads the 32-bit instruction word and one scalar register through a read port. It then works out the new vector length. The upper bound on that length is an 11-bit immediate carried in the instruction. When the source register is not x0, its contents are clamped to that bound. When it is x0, the bound itself is taken as the length.

The length is written back to the destination register if that register is not x0. The destination index is also remembered as the scalar register that now stands in for the vector length, so no control register is needed to hold it. Every result is produced one clock after the instruction is presented, as single-cycle pulses.

A reserved form of the instruction, with bit 31 set, raises an illegal-instruction pulse and changes nothing else. Words that belong to other instructions are ignored.

Top module: `vsetlen_unit`

## Requirements
- R1: An instruction is taken only when `instr_valid` is high, bits [6:0] equal 7'b1010111 and bits [14:12] equal 3'b111. Any other word produces no `wr_en`, `vl_upd` or `illegal` pulse, and `vl_idx` keeps its value.
- R2: A taken word with bit 31 = 1 produces `illegal` high in the following cycle. It produces no `wr_en` or `vl_upd` pulse and leaves `vl_idx` unchanged.
- R3: For a taken word with bit 31 = 0 and rs1 (bits [19:15]) equal to 0, `vl_len` equals the immediate in bits [30:20]. The value on `rf_rdata` has no effect, because x0 reads as zero.
- R4: For a taken word with bit 31 = 0 and rs1 not 0, `vl_len` is the unsigned minimum of `rf_rdata` and the zero-extended 11-bit immediate. A register value with its top bit set is therefore never chosen over the immediate.
- R5: When rd (bits [11:7]) is not 0, `wr_en` pulses with `wr_idx` = rd and `wr_data` = the computed length. When rd is 0, `wr_en` stays low.
- R6: After a set-length operation, `vl_idx` holds its rd, including rd = 0. `vl_idx` changes at no other time, and it is 0 after reset.
- R7: `wr_en`, `vl_upd` and `illegal` are registered. Each is high for exactly one cycle per instruction, in the cycle after it is presented. Back-to-back instructions each give their own pulse, and `vl_len` and `wr_data` are 0 whenever `vl_upd` is low.
- R8: `rf_raddr` always equals bits [19:15] of `instr`, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 32 | Instruction word |
| rf_raddr | output | 5 | Scalar register read index (rs1) |
| rf_rdata | input | 64 | Scalar register read data |
| wr_en | output | 1 | Write-back pulse to the register file |
| wr_idx | output | 5 | Write-back register index |
| wr_data | output | 64 | Write-back value (the new length) |
| vl_upd | output | 1 | Pulse: a new length and length register were set |
| vl_len | output | 64 | New vector length, valid with `vl_upd` |
| vl_idx | output | 5 | Scalar register currently acting as the vector length |
| illegal | output | 1 | Pulse: reserved encoding seen |

## Verification
The bench feeds a register value with its top bit set. A signed comparison would pick that value instead of the immediate. It also checks that the x0 source ignores garbage on the read data, and that a length exactly equal to the bound, or a zero bound, comes through unchanged.

For an rd of x0, the bench checks that the pointer still moves while the write stays low. A design that skipped the pointer update, or wrote x0, would fail there.

The bench presents reserved and foreign words and then reads the pointer back through a later instruction. This catches a decoder that lets them through. Back-to-back and idle cycles catch stretched or merged pulses.

// File: rtl/vsetlen_pkg.sv
// Package: vsetlen_pkg
// Purpose: fixed instruction-format constants and the decoded-instruction
// record shared by the vector length setting unit and its sub-blocks.
// Assumes: the instruction format is fixed at 32 bits, so field positions
// are constants rather than parameters.
package vsetlen_pkg;

    localparam int INSTR_W  = 32;
    localparam int IDX_W    = 5;
    localparam int IMM_W    = 11;
    localparam int OPC_W    = 7;
    localparam int FN3_W    = 3;

    localparam logic [OPC_W-1:0] OPC_VEC   = 7'b1010111;
    localparam logic [FN3_W-1:0] FN3_CFG   = 3'b111;
    localparam logic [IDX_W-1:0] REG_ZERO  = '0;

    // Field positions inside the instruction word
    localparam int OPC_LSB  = 0;
    localparam int RD_LSB   = 7;
    localparam int FN3_LSB  = 12;
    localparam int RS1_LSB  = 15;
    localparam int IMM_LSB  = 20;
    localparam int KIND_BIT = 31;

    typedef enum logic [1:0] {
        OP_NONE     = 2'd0,
        OP_SETLEN   = 2'd1,
        OP_RESERVED = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e          kind;
        logic [IDX_W-1:0]  rs1;
        logic [IDX_W-1:0]  rd;
        logic [IMM_W-1:0]  bound;
    } decoded_t;

endpackage

// File: rtl/vsetlen_decode.sv
// Module: vsetlen_decode
// Purpose: purely combinational field extraction and classification of an
// instruction word into "not ours", "set length" or "reserved".
// Assumes: instr_valid qualifies the word; without it the result is OP_NONE.
module vsetlen_decode
    import vsetlen_pkg::*;
(
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] word_i,
    output decoded_t           dec_o,
    output logic [IDX_W-1:0]   rs1_o
);

    logic [OPC_W-1:0] opc;
    logic [FN3_W-1:0] fn3;
    logic             kind_bit;
    logic             is_ours;

    // Slice the fixed fields out of the word
    always_comb begin
        opc      = word_i[OPC_LSB +: OPC_W];
        fn3      = word_i[FN3_LSB +: FN3_W];
        kind_bit = word_i[KIND_BIT];
    end

    // Match opcode and funct3 for this instruction
    always_comb begin
        is_ours = valid_i && (opc == OPC_VEC) && (fn3 == FN3_CFG);
    end

    // Build the decoded record
    always_comb begin
        dec_o.rs1   = word_i[RS1_LSB +: IDX_W];
        dec_o.rd    = word_i[RD_LSB  +: IDX_W];
        dec_o.bound = word_i[IMM_LSB +: IMM_W];
        if (!is_ours) begin
            dec_o.kind = OP_NONE;
        end else if (kind_bit) begin
            dec_o.kind = OP_RESERVED;
        end else begin
            dec_o.kind = OP_SETLEN;
        end
    end

    // The read index follows the rs1 field directly
    always_comb begin
        rs1_o = word_i[RS1_LSB +: IDX_W];
    end

endmodule

// File: rtl/vsetlen_clamp.sv
// Module: vsetlen_clamp
// Purpose: computes the new length: the bound itself when the source is x0,
// else the unsigned minimum of the source value and the zero-extended bound.
// Assumes: XLEN is at least IMM_W; the source read data of x0 is ignored so
// x0 behaves as zero whatever the register file returns.
module vsetlen_clamp
    import vsetlen_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [IDX_W-1:0] rs1_i,
    input  logic [XLEN-1:0]  src_i,
    input  logic [IMM_W-1:0] bound_i,
    output logic [XLEN-1:0]  len_o
);

    localparam int PAD_W = XLEN - IMM_W;

    logic [XLEN-1:0] bound_x;
    logic [XLEN-1:0] src_eff;
    logic            src_smaller;

    generate
        if (PAD_W > 0) begin : g_pad
            // Zero-extend the bound to the register width
            always_comb begin
                bound_x = {{PAD_W{1'b0}}, bound_i};
            end
        end else begin : g_nopad
            // Register width equals bound width; no extension needed
            always_comb begin
                bound_x = bound_i[XLEN-1:0];
            end
        end
    endgenerate

    // x0 always reads as zero regardless of the read port
    always_comb begin
        src_eff = (rs1_i == REG_ZERO) ? '0 : src_i;
    end

    // Unsigned comparison of source against the bound
    always_comb begin
        src_smaller = (src_eff < bound_x);
    end

    // Select the length: bound for x0, else the smaller of the two
    always_comb begin
        if (rs1_i == REG_ZERO) begin
            len_o = bound_x;
        end else if (src_smaller) begin
            len_o = src_eff;
        end else begin
            len_o = bound_x;
        end
    end

endmodule

// File: rtl/vsetlen_commit.sv
// Module: vsetlen_commit
// Purpose: registers the results of one decoded instruction as one-cycle
// pulses and keeps the index of the register acting as the vector length.
// Assumes: dec_i and len_i are stable in the cycle they are sampled; reset
// is synchronous and active low.
module vsetlen_commit
    import vsetlen_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  decoded_t         dec_i,
    input  logic [XLEN-1:0]  len_i,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [XLEN-1:0]  wr_data_o,
    output logic             upd_o,
    output logic [XLEN-1:0]  len_o,
    output logic [IDX_W-1:0] ptr_o,
    output logic             ill_o
);

    logic set_now;
    logic write_now;
    logic rsvd_now;

    // Classify the incoming decoded record
    always_comb begin
        set_now   = (dec_i.kind == OP_SETLEN);
        rsvd_now  = (dec_i.kind == OP_RESERVED);
        write_now = set_now && (dec_i.rd != REG_ZERO);
    end

    // Write-back pulse and its payload; x0 writes suppressed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o   <= 1'b0;
            wr_idx_o  <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o   <= write_now;
            wr_idx_o  <= write_now ? dec_i.rd : '0;
            wr_data_o <= write_now ? len_i : '0;
        end
    end

    // Length-update pulse and the computed length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_o <= 1'b0;
            len_o <= '0;
        end else begin
            upd_o <= set_now;
            len_o <= set_now ? len_i : '0;
        end
    end

    // Index of the scalar register standing in for the vector length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_o <= '0;
        end else if (set_now) begin
            ptr_o <= dec_i.rd;
        end
    end

    // Reserved-encoding pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ill_o <= 1'b0;
        end else begin
            ill_o <= rsvd_now;
        end
    end

endmodule

// File: rtl/vsetlen_unit.sv
// Module: vsetlen_unit
// Purpose: top of the vector length setting unit; decodes the word, clamps
// the requested length and commits the results one cycle later.
// Assumes: the register file read port is combinational (rf_rdata follows
// rf_raddr in the same cycle); one instruction may arrive every cycle.
module vsetlen_unit
    import vsetlen_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    output logic [IDX_W-1:0]   rf_raddr,
    input  logic [XLEN-1:0]    rf_rdata,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [XLEN-1:0]    wr_data,
    output logic               vl_upd,
    output logic [XLEN-1:0]    vl_len,
    output logic [IDX_W-1:0]   vl_idx,
    output logic               illegal
);

    decoded_t        dec;
    logic [XLEN-1:0] len_c;

    vsetlen_decode u_decode (
        .valid_i (instr_valid),
        .word_i  (instr),
        .dec_o   (dec),
        .rs1_o   (rf_raddr)
    );

    vsetlen_clamp #(.XLEN(XLEN)) u_clamp (
        .rs1_i   (dec.rs1),
        .src_i   (rf_rdata),
        .bound_i (dec.bound),
        .len_o   (len_c)
    );

    vsetlen_commit #(.XLEN(XLEN)) u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_i     (dec),
        .len_i     (len_c),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data),
        .upd_o     (vl_upd),
        .len_o     (vl_len),
        .ptr_o     (vl_idx),
        .ill_o     (illegal)
    );

endmodule

// File: rtl/vsetlen_unit_chk.sv
// Module: vsetlen_unit_chk
// Purpose: temporal properties of the vector length setting unit, attached
// to every instance of the top through a bind statement.
module vsetlen_unit_chk
    import vsetlen_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               instr_valid,
    input logic [INSTR_W-1:0] instr,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_idx,
    input logic [XLEN-1:0]    wr_data,
    input logic               vl_upd,
    input logic [XLEN-1:0]    vl_len,
    input logic [IDX_W-1:0]   vl_idx,
    input logic               illegal
);

    // R1
    no_valid_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!vl_upd && !illegal && !wr_en));

    // R2
    reserved_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && !vl_upd));

    // R4
    len_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> (!vl_upd ||
            (vl_len <= {{(XLEN-IMM_W){1'b0}}, $past(instr[IMM_LSB +: IMM_W])})));

    // R5
    write_matches_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (vl_upd && wr_idx != REG_ZERO && wr_data == vl_len && wr_idx == vl_idx));

    // R6
    ptr_moves_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vl_upd |=> ($stable(vl_idx) || vl_upd));

    // R7
    idle_len_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vl_upd |-> (vl_len == '0 && wr_data == '0));

endmodule

bind vsetlen_unit vsetlen_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .vl_upd      (vl_upd),
    .vl_len      (vl_len),
    .vl_idx      (vl_idx),
    .illegal     (illegal)
);

// File: tb/tb_vsetlen_unit.sv
module tb_vsetlen_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [4:0]  rf_raddr;
    logic [63:0] rf_rdata = '0;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [63:0] wr_data;
    logic        vl_upd;
    logic [63:0] vl_len;
    logic [4:0]  vl_idx;
    logic        illegal;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    vsetlen_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .vl_upd(vl_upd), .vl_len(vl_len), .vl_idx(vl_idx),
        .illegal(illegal)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic k, input logic [10:0] imm,
                                       input logic [4:0] rs1, input logic [4:0] rd);
        return {k, imm, rs1, 3'b111, rd, 7'b1010111};
    endfunction

    // Drive at negedge; result registered at next posedge, sampled next negedge
    task automatic issue(input logic [31:0] w, input logic [63:0] rd_val);
        @(negedge clk);
        instr_valid = 1'b1;
        instr = w;
        rf_rdata = rd_val;
        @(negedge clk);
        instr_valid = 1'b0;
        instr = '0;
        rf_rdata = 64'hDEAD_BEEF_DEAD_BEEF;
    endtask

    task automatic expect_set(input string tag, input logic [4:0] rd, input logic [63:0] len);
        chk(vl_upd == 1'b1, tag, {63'd0, vl_upd}, 64'd1);
        chk(vl_len == len, tag, vl_len, len);
        chk(vl_idx == rd, tag, {59'd0, vl_idx}, {59'd0, rd});
        chk(wr_en == (rd != 0), tag, {63'd0, wr_en}, {63'd0, rd != 0});
        if (rd != 0) begin
            chk(wr_idx == rd && wr_data == len, tag, wr_data, len);
        end
        chk(illegal == 1'b0, tag, {63'd0, illegal}, 64'd0);
    endtask

    task automatic expect_quiet(input string tag);
        chk(!vl_upd && !wr_en && !illegal, tag,
            {61'd0, vl_upd, wr_en, illegal}, 64'd0);
    endtask

    task automatic t_reset();
        chk(!vl_upd && !wr_en && !illegal && vl_idx == 0 && vl_len == 0,
            "R6 reset state", {59'd0, vl_idx}, 64'd0);
    endtask

    task automatic t_raddr();
        @(negedge clk);
        instr = mk(1'b0, 11'd9, 5'd19, 5'd2);
        #1;
        chk(rf_raddr == 5'd19, "R8 read index", {59'd0, rf_raddr}, 64'd19);
        instr = 32'h0000_5A00;
        #1;
        chk(rf_raddr == 5'd0, "R8 read index change", {59'd0, rf_raddr}, 64'd0);
        instr = '0;
    endtask

    task automatic t_rs1_zero();
        issue(mk(1'b0, 11'd50, 5'd0, 5'd3), 64'd7);
        expect_set("R3 x0 source gives bound", 5'd3, 64'd50);
        issue(mk(1'b0, 11'd0, 5'd0, 5'd4), 64'hFFFF);
        expect_set("R3 zero bound", 5'd4, 64'd0);
    endtask

    task automatic t_clamp();
        issue(mk(1'b0, 11'd100, 5'd6, 5'd5), 64'd5);
        expect_set("R4 source below bound", 5'd5, 64'd5);
        issue(mk(1'b0, 11'd2047, 5'd6, 5'd7), 64'd3000);
        expect_set("R4 source above bound", 5'd7, 64'd2047);
        issue(mk(1'b0, 11'd100, 5'd6, 5'd8), 64'd100);
        expect_set("R4 source equal bound", 5'd8, 64'd100);
        issue(mk(1'b0, 11'd20, 5'd9, 5'd10), 64'h8000_0000_0000_0003);
        expect_set("R4 unsigned top bit", 5'd10, 64'd20);
    endtask

    task automatic t_rd_zero();
        issue(mk(1'b0, 11'd33, 5'd0, 5'd0), 64'd0);
        expect_set("R5 rd x0 no write", 5'd0, 64'd33);
    endtask

    task automatic t_reserved();
        issue(mk(1'b0, 11'd12, 5'd0, 5'd11), 64'd0);
        issue(mk(1'b1, 11'd40, 5'd0, 5'd12), 64'd0);
        chk(illegal == 1'b1, "R2 reserved flagged", {63'd0, illegal}, 64'd1);
        chk(!wr_en && !vl_upd, "R2 reserved no write", {62'd0, wr_en, vl_upd}, 64'd0);
        chk(vl_idx == 5'd11, "R2 pointer kept", {59'd0, vl_idx}, 64'd11);
        @(negedge clk);
        chk(illegal == 1'b0, "R7 illegal one cycle", {63'd0, illegal}, 64'd0);
    endtask

    task automatic t_foreign();
        logic [31:0] w;
        w = mk(1'b0, 11'd5, 5'd0, 5'd13);
        w[6:0] = 7'b0110011;
        issue(w, 64'd0);
        expect_quiet("R1 other opcode");
        chk(vl_idx == 5'd11, "R1 other opcode pointer", {59'd0, vl_idx}, 64'd11);
        w = mk(1'b0, 11'd5, 5'd0, 5'd14);
        w[14:12] = 3'b011;
        issue(w, 64'd0);
        expect_quiet("R1 other funct3");
        @(negedge clk);
        instr = mk(1'b0, 11'd5, 5'd0, 5'd15);
        @(negedge clk);
        instr = '0;
        expect_quiet("R1 not valid");
        chk(vl_idx == 5'd11, "R1 not valid pointer", {59'd0, vl_idx}, 64'd11);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        instr_valid = 1'b1;
        instr = mk(1'b0, 11'd64, 5'd0, 5'd20);
        @(negedge clk);
        expect_set("R7 first of pair", 5'd20, 64'd64);
        instr = mk(1'b0, 11'd64, 5'd21, 5'd22);
        rf_rdata = 64'd17;
        @(negedge clk);
        instr_valid = 1'b0;
        instr = '0;
        expect_set("R7 second of pair", 5'd22, 64'd17);
        @(negedge clk);
        expect_quiet("R7 pulse ends");
        chk(vl_len == 0 && wr_data == 0, "R7 idle data zero", vl_len, 64'd0);
        chk(vl_idx == 5'd22, "R6 pointer held", {59'd0, vl_idx}, 64'd22);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_raddr();
        t_rs1_zero();
        t_clamp();
        t_rd_zero();
        t_reserved();
        t_foreign();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule